// File: doc/BRIEF.md
# Four-level page walker with upper-level entry cache

This block resolves a TLB miss. It takes a 48-bit virtual address and the frame number of the root table. It then reads entries of a four-level radix page table from memory, one load at a time, until it reaches the leaf entry that gives the physical frame number. The low twelve address bits are the offset within the page, and the walker never translates them. The walker reports a completed walk in two ways: a one-cycle response carrying either the frame number or a fault, and in the same cycle a fill strobe that writes the new translation into a TLB.

A small cache holds non-leaf entries, split by table level. Each slot is keyed by a prefix of the virtual address: bits 47:39, 47:30 or 47:21. On a new request the deepest matching prefix supplies the base of a lower table, so the walk starts further down the tree and issues fewer loads. A one-cycle invalidate input empties the whole cache. The walker handles one miss at a time.

Top module: `ptw_walker`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle, including straight after reset. A request is taken on a cycle with `req_valid` and `req_ready` both high. A request presented while a walk is in progress is dropped.
- R2: Each load reads address `{table_base, index, 3'b000}`. The index is virtual address bits 47:39, 38:30, 29:21 or 20:12 for the first, second, third and fourth table level respectively.
- R3: A table entry is valid when bit 0 is 1, and its bits 51:12 are the frame number of the next table, or of the page at the leaf level. With no cached prefix, a walk issues four sequential loads, and the first one indexes the root table.
- R4: Before loading, the walker uses the deepest cached match. A match on 47:21 leaves one load, a match on 47:30 leaves two, and a match on 47:39 leaves three.
- R5: An entry with bit 0 clear at any level ends the walk at once. No further load is issued, the response has `rsp_fault` set, and no TLB fill occurs.
- R6: A successful walk raises `rsp_valid` for exactly one cycle, the cycle after the final load is acknowledged. In that cycle `rsp_pfn` is the leaf entry's bits 51:12. `tlb_fill_valid` is asserted in the same cycle with `tlb_fill_vpn` equal to virtual address bits 47:12. Offset bits 11:0 do not affect the result.
- R7: Every valid non-leaf entry that a walk fetches is inserted into its level's part of the cache, even when the walk later faults. Each level has `PSC_N` slots, replaced round-robin.
- R8: A one-cycle pulse on `inval` clears every cached entry. A walk accepted afterwards starts again at the root.
- R9: While `mem_rd_valid` is high and `mem_rd_ack` is low, the load request and its address are held steady. Only one load is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inval | input | 1 | Flush all cached upper-level entries |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 48 | Virtual address that missed |
| req_root | input | PA_W-12 | Frame number of the root table |
| mem_rd_valid | output | 1 | Page-table load request |
| mem_rd_addr | output | PA_W | Byte address of the 64-bit entry |
| mem_rd_ack | input | 1 | Load data valid this cycle |
| mem_rd_data | input | 64 | Entry read from memory |
| rsp_valid | output | 1 | Walk finished (one-cycle pulse) |
| rsp_fault | output | 1 | Walk hit a non-present entry |
| rsp_pfn | output | PA_W-12 | Translated physical frame number |
| tlb_fill_valid | output | 1 | Write translation into TLB |
| tlb_fill_vpn | output | 36 | Virtual page number to fill |
| tlb_fill_pfn | output | PA_W-12 | Physical frame number to fill |

## Verification
The bench aims at the prefix lookup by changing one index field at a time, so that a fixed number of loads is expected: one, two, three or four. A lookup that preferred a shallow match over a deep one, or compared the wrong bit range, would issue the wrong number of loads or read from the wrong table. Faults are placed at the first and third levels, and the third-level fault is then repeated so that it must be served from entries cached by the faulting walk. A walker that still filled the TLB, kept loading, or skipped caching on a fault would show up as a wrong fill strobe or a wrong load count. One more prefix than there are slots is walked, and then the oldest and a surviving prefix are revisited, to catch replacement that is not round-robin. A flush followed by a repeat walk, and a request presented mid-walk, catch stale cache contents and lost busy gating.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int PSC_N = 4,
  parameter int PA_W  = 52
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [47:0]       req_va,
  input  logic [PA_W-13:0]  req_root,
  output logic              mem_rd_valid,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [63:0]       mem_rd_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-13:0]  rsp_pfn,
  output logic              tlb_fill_valid,
  output logic [35:0]       tlb_fill_vpn,
  output logic [PA_W-13:0]  tlb_fill_pfn
);
  localparam int FN_W = PA_W - 12;
  localparam int IW   = (PSC_N > 1) ? $clog2(PSC_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RESP} st_t;

  st_t              st_q;
  logic [1:0]       lvl_q;
  logic [FN_W-1:0]  base_q;
  logic [47:0]      va_q;

  logic [26:0]      tag_q [3][PSC_N];
  logic [FN_W-1:0]  nxt_q [3][PSC_N];
  logic [PSC_N-1:0] vld_q [3];
  logic [IW-1:0]    ptr_q [3];

  logic [1:0]       hit_lvl;
  logic [FN_W-1:0]  hit_base;

  function automatic logic [26:0] kmask(input int l);
    kmask = (l == 0) ? {9'h1FF, 18'h0} : (l == 1) ? {18'h3FFFF, 9'h0} : {27{1'b1}};
  endfunction

  always_comb begin
    hit_lvl  = '0;
    hit_base = req_root;
    for (int l = 0; l < 3; l++)
      for (int e = 0; e < PSC_N; e++)
        if (!inval && vld_q[l][e] && tag_q[l][e] == (req_va[47:21] & kmask(l))) begin
          hit_lvl  = 2'(l + 1);
          hit_base = nxt_q[l][e];
        end
  end

  logic [47:0]     va_sh;
  logic [FN_W-1:0] next_base;
  logic            take, ins, unused_bits;

  assign va_sh        = va_q >> (6'd39 - 6'd9 * {4'd0, lvl_q});
  assign mem_rd_valid = (st_q == S_LOAD);
  assign mem_rd_addr  = {base_q, va_sh[8:0], 3'b000};
  assign next_base    = mem_rd_data[PA_W-1:12];
  assign take         = mem_rd_valid && mem_rd_ack;
  assign ins          = take && mem_rd_data[0] && (lvl_q != 2'd3) && !inval;
  assign unused_bits  = ^{mem_rd_data[63:PA_W], mem_rd_data[11:1], va_sh[47:9]};

  assign req_ready      = (st_q == S_IDLE);
  assign rsp_valid      = (st_q == S_RESP);
  assign tlb_fill_valid = rsp_valid && !rsp_fault;
  assign tlb_fill_vpn   = va_q[47:12];
  assign tlb_fill_pfn   = rsp_pfn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      lvl_q     <= '0;
      base_q    <= '0;
      va_q      <= '0;
      rsp_fault <= 1'b0;
      rsp_pfn   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          lvl_q  <= hit_lvl;
          base_q <= hit_base;
          st_q   <= S_LOAD;
        end
        S_LOAD: if (take) begin
          if (!mem_rd_data[0]) begin
            rsp_fault <= 1'b1;
            st_q      <= S_RESP;
          end else if (lvl_q == 2'd3) begin
            rsp_fault <= 1'b0;
            rsp_pfn   <= next_base;
            st_q      <= S_RESP;
          end else begin
            base_q <= next_base;
            lvl_q  <= lvl_q + 2'd1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 3; l++) begin
        vld_q[l] <= '0;
        ptr_q[l] <= '0;
      end
    end else if (inval) begin
      for (int l = 0; l < 3; l++) vld_q[l] <= '0;
    end else begin
      for (int l = 0; l < 3; l++)
        if (ins && lvl_q == 2'(l)) begin
          vld_q[l][ptr_q[l]] <= 1'b1;
          ptr_q[l] <= (ptr_q[l] == IW'(PSC_N - 1)) ? '0 : ptr_q[l] + 1'b1;
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < 3; l++)
      if (ins && lvl_q == 2'(l)) begin
        tag_q[l][ptr_q[l]] <= va_q[47:21] & kmask(l);
        nxt_q[l][ptr_q[l]] <= next_base;
      end
  end
endmodule

// File: rtl/ptw_walker_sva.sv
module ptw_walker_sva #(
  parameter int PA_W = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_rd_valid,
  input logic [PA_W-1:0] mem_rd_addr,
  input logic            mem_rd_ack,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic            tlb_fill_valid
);
  logic [2:0] loads_q;

  always_ff @(posedge clk) begin
    if (!rst_n) loads_q <= '0;
    else if (req_valid && req_ready) loads_q <= '0;
    else if (mem_rd_valid && mem_rd_ack && loads_q != 3'd7) loads_q <= loads_q + 3'd1;
  end

  p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || rsp_valid) |-> !req_ready);

  p_addr_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (mem_rd_addr[2:0] == 3'b000));

  p_load_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (loads_q >= 3'd1 && loads_q <= 3'd4));

  p_fault_nofill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !tlb_fill_valid);

  p_fill_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_fill_valid |-> (rsp_valid && !rsp_fault));

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(mem_rd_valid && mem_rd_ack));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

bind ptw_walker ptw_walker_sva #(.PA_W(PA_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .tlb_fill_valid(tlb_fill_valid)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  localparam int PA_W = 52;
  localparam logic [39:0] ROOT = 40'h00012;

  logic clk = 1'b0, rst_n = 1'b0, inval = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [47:0] req_va = '0;
  logic [39:0] req_root = ROOT;
  logic mem_rd_valid, mem_rd_ack = 1'b0;
  logic [51:0] mem_rd_addr;
  logic [63:0] mem_rd_data = '0;
  logic rsp_valid, rsp_fault, tlb_fill_valid;
  logic [39:0] rsp_pfn, tlb_fill_pfn;
  logic [35:0] tlb_fill_vpn;

  ptw_walker #(.PSC_N(4), .PA_W(PA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .inval(inval),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_root(req_root),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_pfn(rsp_pfn), .tlb_fill_valid(tlb_fill_valid), .tlb_fill_vpn(tlb_fill_vpn),
    .tlb_fill_pfn(tlb_fill_pfn));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, nloads = 0, lat = 0;
  logic [51:0] first_addr = '0;

  function automatic logic [63:0] ent(input logic [51:0] a);
    logic [48:0] p;
    p = a[51:3] * 49'd13 + 49'd7;
    return {12'h0, p[39:0], 11'h0, (a[11:3] != 9'h1FF)};
  endfunction

  function automatic logic [40:0] model(input logic [39:0] root, input logic [47:0] va);
    logic [39:0] b;
    logic [47:0] s;
    logic [63:0] e;
    b = root;
    for (int lv = 0; lv < 4; lv++) begin
      s = va >> (39 - 9 * lv);
      e = ent({b, s[8:0], 3'b000});
      if (!e[0]) return {1'b1, 40'h0};
      b = e[51:12];
    end
    return {1'b0, b};
  endfunction

  function automatic logic [47:0] mkva(input int i1, input int i2, input int i3, input int i4, input int off);
    return {9'(i1), 9'(i2), 9'(i3), 9'(i4), 12'(off)};
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      mem_rd_ack = 1'b0;
      if (mem_rd_valid) begin
        repeat (lat) @(negedge clk);
        mem_rd_data = ent(mem_rd_addr);
        mem_rd_ack  = 1'b1;
        nloads++;
        if (nloads == 1) first_addr = mem_rd_addr;
        lat = (lat + 1) % 3;
      end
    end
  end

  task automatic flush();
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
  endtask

  task automatic walk(input logic [47:0] va, input int exp_loads, input string rq, input bit inj);
    logic [40:0] m;
    int t;
    m = model(ROOT, va);
    @(negedge clk);
    chk("R1", "ready before request", req_ready, 1);
    nloads = 0; req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = inj; req_va = va ^ 48'h8000_0000_0000;
    if (inj) begin @(negedge clk); req_valid = 1'b0; end
    t = 0;
    while (!rsp_valid && t < 300) begin @(negedge clk); t++; end
    chk(rq, "response arrived", rsp_valid, 1);
    chk(rq, "fault flag", rsp_fault, m[40]);
    if (!m[40]) begin
      chk(rq, "pfn", rsp_pfn, m[39:0]);
      chk("R6", "fill strobe", tlb_fill_valid, 1);
      chk("R6", "fill vpn", tlb_fill_vpn, va[47:12]);
      chk("R6", "fill pfn", tlb_fill_pfn, m[39:0]);
    end else begin
      chk("R5", "no fill on fault", tlb_fill_valid, 0);
    end
    if (exp_loads >= 0) chk(rq, "load count", nloads, exp_loads);
    @(negedge clk);
    chk("R6", "single-cycle response", rsp_valid, 0);
    if (inj) begin
      chk("R1", "busy request dropped, idle", req_ready, 1);
      chk("R1", "busy request dropped, no load", mem_rd_valid, 0);
      chk("R1", "busy request dropped, loads", nloads, exp_loads);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset ready", req_ready, 1);
    chk("R1", "reset no response", rsp_valid, 0);
    chk("R9", "reset no load", mem_rd_valid, 0);
    chk("R6", "reset no fill", tlb_fill_valid, 0);

    // R3 cold walk, root first
    walk(mkva(1, 2, 3, 4, 'h123), 4, "R3", 0);
    chk("R3", "first load at root", first_addr, {ROOT, 9'd1, 3'b000});
    // R4 deepest prefix, offset ignored (R6)
    walk(mkva(1, 2, 3, 5, 'hFFF), 1, "R4", 0);
    chk("R2", "leaf index from 20:12", first_addr[11:3], 9'd5);
    walk(mkva(1, 2, 3, 4, 'h000), 1, "R6", 0);
    walk(mkva(1, 2, 6, 4, 0), 2, "R4", 0);
    chk("R2", "index from 29:21", first_addr[11:3], 9'd6);
    walk(mkva(1, 7, 3, 4, 0), 3, "R4", 0);
    chk("R2", "index from 38:30", first_addr[11:3], 9'd7);
    walk(mkva(8, 2, 3, 4, 0), 4, "R4", 0);
    // R5 faults
    walk(mkva('h1FF, 2, 3, 4, 0), 1, "R5", 0);
    walk(mkva(10, 1, 'h1FF, 4, 0), 3, "R5", 0);
    walk(mkva(10, 1, 'h1FF, 4, 0), 1, "R7", 0);
    // R8 flush, R1 busy drop
    flush();
    walk(mkva(1, 2, 3, 4, 0), 4, "R8", 1);
    // R7 round-robin
    flush();
    for (int p = 20; p < 25; p++) walk(mkva(p, 1, 1, 1, 0), 4, "R7", 0);
    walk(mkva(24, 1, 1, 2, 0), 1, "R7", 0);
    walk(mkva(20, 1, 1, 2, 0), 4, "R7", 0);
    walk(mkva(22, 1, 1, 2, 0), 1, "R7", 0);
    walk(mkva(21, 1, 1, 2, 0), 4, "R7", 0);
    // sweep
    for (int k = 0; k < 40; k++)
      walk(mkva((k * 37) % 512, (k * 11) % 512, (k * 5) % 512, (k * 3) % 512, (k * 97) % 4096),
           -1, "R6", 0);
    flush();
    walk(mkva(0, 0, 0, 0, 0), 4, "R8", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule